// File: doc/BRIEF.md
# Dual-Strobe Reversible Binary Counter

This block is a small reversible binary counter with no direction input. It has two count strobes: a rising edge on the up strobe, taken while the down strobe rests high, advances the count, and a rising edge on the down strobe, taken while the up strobe rests high, steps it back. Both strobes are sampled on one system clock through a synchronizer and a rising-edge detector. The count therefore moves on the third clock edge after a strobe rises, with the default two synchronizer stages.

A master clear forces the count to zero and overrides everything else. An active-low parallel load makes the count follow a data word. Both act on the output at once, without waiting for a clock edge. Two active-low terminal-count outputs copy the low phase of the matching strobe when the count sits at its top value (carry) or at zero (borrow). Wiring carry to the next stage's up strobe and borrow to its down strobe chains several counters into a wider one with no extra logic.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on `up_strobe_i` while `dn_strobe_i` stays high increments `count_o` by one. The new value appears after the third rising `clk` edge that follows the strobe change.
- R2: A rising edge on `dn_strobe_i` while `up_strobe_i` stays high decrements `count_o` by one, with the same latency as R1.
- R3: While `clear_i` is high, `count_o` is zero at once. Load, data and both strobes have no effect during this time, and the count is still zero after `clear_i` falls.
- R4: While `load_n_i` is low and `clear_i` is low, `count_o` equals `data_i` and tracks changes of `data_i`. After `load_n_i` rises, the count keeps the last loaded value.
- R5: `carry_n_o` is low exactly when `count_o` equals all ones (15) and `up_strobe_i` is low. Otherwise it is high.
- R6: `borrow_n_o` is low exactly when `count_o` equals zero and `dn_strobe_i` is low. Otherwise it is high.
- R7: Counting up from 15 gives 0, and counting down from 0 gives 15.
- R8: A strobe that is held low through a clear or a load, and released after the clear or load ends, is counted on its next rising edge.
- R9: A strobe that rises while the other strobe is low leaves the count unchanged. Two strobes that rise in the same clock cycle also leave it unchanged.
- R10: Two counters chained carry-to-up and borrow-to-down count as one 8-bit counter across the 15-to-0 and 0-to-15 nibble boundaries.
- R11: While `rst_n` is low, `count_o` is zero, and both terminal-count outputs are high when both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Master clear, active high, highest priority |
| load_n_i | input | 1 | Parallel load, active low |
| data_i | input | WIDTH | Parallel load value |
| up_strobe_i | input | 1 | Count-up strobe, counted on its rising edge |
| dn_strobe_i | input | 1 | Count-down strobe, counted on its rising edge |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low carry, a copy of the up strobe at the top count |
| borrow_n_o | output | 1 | Active-low borrow, a copy of the down strobe at zero |

## Verification
The test drives two chained instances with several kinds of strobe pulse:
- plain up and down pulses with the other strobe high;
- pulses that cross the nibble boundary in both directions, so that the upper stage must step exactly when the lower one wraps;
- pulses given while the other strobe is low, which must not count;
- both strobes rising together, which must not count;
- strobes held low across a clear or a load and released afterwards, which must count.

A behavioural model predicts the 8-bit value and both terminal outputs of the lower stage on every cycle. Clear and load are applied with data changes and strobe activity underneath them, which separates a true override from one that merely delays the effect.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // Action decided for the count register in one clock cycle.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10
  } step_e;
endpackage

// File: rtl/dsc_strobe_sync.sv
// Brings an asynchronous strobe into the clk domain and flags its rising edge.
// The history resets to the idle-high level and keeps running during clear and load.
module dsc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= strobe_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dsc_step_decode.sv
// A rise counts only when the opposite strobe is high and did not rise in the same cycle.
module dsc_step_decode
  import dsc_pkg::*;
(
  input  logic  up_rise_i,
  input  logic  up_level_i,
  input  logic  dn_rise_i,
  input  logic  dn_level_i,
  output step_e step_o
);
  always_comb begin
    step_o = STEP_HOLD;
    if (up_rise_i && dn_level_i && !dn_rise_i)      step_o = STEP_INC;
    else if (dn_rise_i && up_level_i && !up_rise_i) step_o = STEP_DEC;
  end
endmodule

// File: rtl/dsc_count_core.sv
// The count register. Clear resets it asynchronously. While load is low the
// register takes the data word on every clock.
module dsc_count_core
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] count_q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    if (!load_n_i) begin
      count_d  = data_i;
      count_en = 1'b1;
    end else begin
      unique case (step_i)
        STEP_INC: begin count_d = count_q + ONE; count_en = 1'b1; end
        STEP_DEC: begin count_d = count_q - ONE; count_en = 1'b1; end
        default:  begin count_d = count_q;       count_en = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge clear_i) begin
    if (!rst_n)        count_q <= '0;
    else if (clear_i)  count_q <= '0;
    else if (count_en) count_q <= count_d;
  end
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_strobe_i,
  input  logic             dn_strobe_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  logic             up_level, up_rise, dn_level, dn_rise;
  step_e            step;
  logic [WIDTH-1:0] count_q;

  dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst_n(rst_n), .strobe_i(up_strobe_i),
    .level_o(up_level), .rise_o(up_rise)
  );

  dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst_n(rst_n), .strobe_i(dn_strobe_i),
    .level_o(dn_level), .rise_o(dn_rise)
  );

  dsc_step_decode u_decode (
    .up_rise_i(up_rise), .up_level_i(up_level),
    .dn_rise_i(dn_rise), .dn_level_i(dn_level),
    .step_o(step)
  );

  dsc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_n_i(load_n_i),
    .data_i(data_i), .step_i(step), .count_q(count_q)
  );

  // Clear and load reach the output without waiting for a clock edge.
  always_comb begin
    if (clear_i)        count_o = '0;
    else if (!load_n_i) count_o = data_i;
    else                count_o = count_q;
  end

  // Terminal outputs gate the raw strobe, so they copy its waveform for chaining.
  assign carry_n_o  = ~((count_o == TOP_VAL) & ~up_strobe_i);
  assign borrow_n_o = ~((count_o == BOT_VAL) & ~dn_strobe_i);
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             load_n_i,
  input logic [WIDTH-1:0] data_i,
  input logic             up_strobe_i,
  input logic             dn_strobe_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o,
  input logic             borrow_n_o
);
  logic [WIDTH-1:0] prev_cnt, prev_up, prev_dn;
  logic             prev_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cnt  <= '0;
      prev_free <= 1'b0;
    end else begin
      prev_cnt  <= count_o;
      prev_free <= load_n_i & ~clear_i;
    end
  end
  assign prev_up = prev_cnt + WIDTH'(1);
  assign prev_dn = prev_cnt - WIDTH'(1);

  // R1 R2 R7
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_free && load_n_i && !clear_i) |->
      (count_o == prev_cnt || count_o == prev_up || count_o == prev_dn));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> (count_o == '0));

  // R4
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !load_n_i) |-> (count_o == data_i));

  // R5
  carry_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |-> !up_strobe_i);

  // R6
  borrow_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n_o |-> !dn_strobe_i);

  // R5 R6
  terminal_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~carry_n_o, ~borrow_n_o}));
endmodule

bind dual_strobe_counter dsc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_n_i(load_n_i),
  .data_i(data_i), .up_strobe_i(up_strobe_i), .dn_strobe_i(dn_strobe_i),
  .count_o(count_o), .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
);

// File: tb/dual_strobe_counter_tb.sv
module dual_strobe_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n, clr, ld_n, up, dn;
  logic [7:0] data8;
  logic [3:0] cnt_lo, cnt_hi;
  logic       car_lo, bor_lo, car_hi, bor_hi;

  always #2.5 clk = ~clk;

  dual_strobe_counter u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clr), .load_n_i(ld_n), .data_i(data8[3:0]),
    .up_strobe_i(up), .dn_strobe_i(dn), .count_o(cnt_lo),
    .carry_n_o(car_lo), .borrow_n_o(bor_lo));

  dual_strobe_counter u_hi (
    .clk(clk), .rst_n(rst_n), .clear_i(clr), .load_n_i(ld_n), .data_i(data8[7:4]),
    .up_strobe_i(car_lo), .dn_strobe_i(bor_lo), .count_o(cnt_hi),
    .carry_n_o(car_hi), .borrow_n_o(bor_hi));

  int    total = 0, bad = 0, cyc = 0, m = 0;
  int    pq_cyc[$], pq_d[$];
  bit    started = 0, finished = 0;
  string req = "R11";

  // Reference model: pending steps land on the third clock edge after a strobe rise.
  always @(posedge clk) begin
    cyc++;
    if (pq_cyc.size() > 0 && pq_cyc[0] == cyc) begin
      if (rst_n && !clr && ld_n) m = (m + pq_d[0] + 256) % 256;
      void'(pq_cyc.pop_front());
      void'(pq_d.pop_front());
    end
    if (!rst_n || clr) m = 0;
    else if (!ld_n)    m = int'(data8);
  end

  function automatic int shown();
    if (!rst_n || clr) return 0;
    if (!ld_n)         return int'(data8);
    return m;
  endfunction

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      int e;
      e = shown();
      check("count", int'({cnt_hi, cnt_lo}), e);
      // R5 carry and R6 borrow of the lower stage
      check("carry", int'(car_lo), ((e % 16) == 15 && !up) ? 0 : 1);
      check("borrow", int'(bor_lo), ((e % 16) == 0 && !dn) ? 0 : 1);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_strobes(input logic nu, input logic nd);
    wait_clk(1);
    if (nu && !up && dn && nd) begin pq_cyc.push_back(cyc + 3); pq_d.push_back(1);  end
    if (nd && !dn && up && nu) begin pq_cyc.push_back(cyc + 3); pq_d.push_back(-1); end
    up = nu;
    dn = nd;
  endtask

  task automatic pulse_up(input int n);
    for (int i = 0; i < n; i++) begin
      set_strobes(1'b0, dn); wait_clk(3);
      set_strobes(1'b1, dn); wait_clk(4);
    end
  endtask

  task automatic pulse_dn(input int n);
    for (int i = 0; i < n; i++) begin
      set_strobes(up, 1'b0); wait_clk(3);
      set_strobes(up, 1'b1); wait_clk(4);
    end
  endtask

  task automatic load(input logic [7:0] v);
    wait_clk(1); data8 = v; ld_n = 1'b0;
    wait_clk(3); ld_n = 1'b1;
    wait_clk(2);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; ld_n = 1'b1; up = 1'b1; dn = 1'b1; data8 = 8'h00;
    repeat (3) @(posedge clk);
    started = 1;
    wait_clk(2);
    // R11 reset state
    check("reset_count", int'({cnt_hi, cnt_lo}), 0);
    check("reset_carry", int'(car_hi & car_lo), 1);
    check("reset_borrow", int'(bor_hi & bor_lo), 1);
    rst_n = 1'b1;
    wait_clk(3);

    req = "R1";  pulse_up(4);
    check("after_up4", int'({cnt_hi, cnt_lo}), 4);
    req = "R2";  pulse_dn(2);
    check("after_dn2", int'({cnt_hi, cnt_lo}), 2);
    req = "R7";  pulse_dn(3);
    // R10 borrow chain: 0x00 - 1 = 0xFF
    check("wrap_down", int'({cnt_hi, cnt_lo}), 8'hFF);
    pulse_up(1);
    check("wrap_up", int'({cnt_hi, cnt_lo}), 0);

    req = "R4";
    wait_clk(1); data8 = 8'h5A; ld_n = 1'b0;
    wait_clk(2); data8 = 8'h3E;
    wait_clk(2); ld_n = 1'b1;
    wait_clk(3);
    check("load_hold", int'({cnt_hi, cnt_lo}), 8'h3E);

    req = "R5";
    pulse_up(1);
    set_strobes(1'b0, 1'b1); wait_clk(3);
    check("carry_low", int'(car_lo), 0);
    req = "R10";
    set_strobes(1'b1, 1'b1); wait_clk(4);
    check("carry_chain", int'({cnt_hi, cnt_lo}), 8'h40);

    req = "R3";
    wait_clk(1); clr = 1'b1; ld_n = 1'b0; data8 = 8'h77;
    wait_clk(2);
    set_strobes(1'b0, 1'b1); wait_clk(2);
    set_strobes(1'b1, 1'b1); wait_clk(5);
    ld_n = 1'b1; wait_clk(2);
    clr = 1'b0; wait_clk(4);
    check("clear_zero", int'({cnt_hi, cnt_lo}), 0);

    req = "R8";
    set_strobes(1'b0, 1'b1);
    wait_clk(1); clr = 1'b1; wait_clk(3); clr = 1'b0; wait_clk(4);
    set_strobes(1'b1, 1'b1); wait_clk(4);
    check("held_through_clear", int'({cnt_hi, cnt_lo}), 1);
    set_strobes(1'b1, 1'b0);
    load(8'h25); wait_clk(2);
    set_strobes(1'b1, 1'b1); wait_clk(4);
    check("held_through_load", int'({cnt_hi, cnt_lo}), 8'h24);

    req = "R9";
    set_strobes(1'b1, 1'b0); wait_clk(2);
    pulse_up(1);
    check("up_while_dn_low", int'({cnt_hi, cnt_lo}), 8'h24);
    set_strobes(1'b1, 1'b1); wait_clk(4);
    check("dn_after", int'({cnt_hi, cnt_lo}), 8'h23);
    set_strobes(1'b0, 1'b0); wait_clk(3);
    set_strobes(1'b1, 1'b1); wait_clk(4);
    check("both_rise", int'({cnt_hi, cnt_lo}), 8'h23);

    req = "R10";
    load(8'h0D);
    pulse_up(5);
    check("cascade_up", int'({cnt_hi, cnt_lo}), 8'h12);
    pulse_dn(5);
    check("cascade_dn", int'({cnt_hi, cnt_lo}), 8'h0D);

    wait_clk(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule